// File: doc/BRIEF.md
# ECC-Protected Static Memory Cycle Controller

This block holds the control logic and the data path for a 32-bit word memory that protects every stored word with a single-error-correcting, double-error-detecting Hamming code. A processor starts an access by raising an address strobe while the board select is high. The block then latches the word address, the direction, the byte enables and the write data, and runs one of three sequences. A full-word write stores the data and fresh check bits at once. A read checks the stored word, corrects any single-bit fault and returns the data. A write that enables only some byte lanes runs as a read, then a correction, then a merge of the enabled lanes, then a write-back of the word with all check bits recomputed.

The wait output stays low for clean reads and full-word writes, so these run at plain memory speed. It rises only to stretch a read that met a fault and to cover the read-merge-write of a partial write. Two outputs report faults. One is active low and marks a corrected single-bit fault. The other is active high and marks an uncorrectable multi-bit fault, which means the returned data is not valid. The storage is an internal array of 40-bit words whose depth is set by a parameter.

Top module: `ecc_mem_ctrl`

## Requirements
- R1: A cycle starts only on a rising clock edge where `ale`, `bsel` and the idle state are all true. An edge with `ale` high and `bsel` low starts nothing: no word changes and `data_oe` stays low.
- R2: `rw` = 1 selects a read. In the cycle after the start edge, `data_oe` is 1 and `data_out` carries the stored word. For a clean word, `wait_o` stays 0 and `data_oe` drops after one cycle.
- R3: `rw` = 0 with `be_n` = 4'b0000 is a full-word write. It stores `data_in` on the start edge and `wait_o` never rises.
- R4: A write with `be_n` not 4'b0000 is a partial write. Bit `be_n[i]` is active low and governs data bits 8i+7..8i. `wait_o` is 1 for exactly the one cycle after the start edge, and the merged word is written on the edge that ends that cycle. Disabled lanes keep their old value.
- R5: On a read of a word with one flipped bit, `data_out` carries the corrected data and `err_n` is 0. `wait_o` is 1 in the first read cycle and 0 in a second read cycle, during which the data is still driven.
- R6: On a read of a word with two flipped bits, `merr` is 1, `err_n` stays 1, and `wait_o` is 1 in the first read cycle.
- R7: A partial write onto a word with one flipped bit merges into the corrected data and drives `err_n` low during its wait cycle. A later read of that word is clean.
- R8: A partial write onto a word with two flipped bits still writes back, with `merr` high during its wait cycle. The uncorrected data forms the base of the merge, the check bits are recomputed, and a later read of that word is clean.
- R9: `data_oe` is 0 outside read cycles, and `data_out` is 0 whenever `data_oe` is 0.
- R10: A stored word holds data in bits 31..0 and Hamming checks in bits 37..32, with bit 32+k set to the parity of the data bits whose code position has bit k set. Data bits take, in order, the code positions 1..38 that are not powers of two. Bit 38 is the parity of bits 37..0, and bit 39 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ale | input | 1 | Address strobe, starts a cycle |
| bsel | input | 1 | Board select, active high |
| rw | input | 1 | 1 = read, 0 = write |
| be_n | input | 4 | Byte lane enables for writes, active low |
| word_addr | input | AW | Word address (processor address bits 2 and up) |
| data_in | input | 32 | Write data from the bus |
| data_out | output | 32 | Read data toward the bus |
| data_oe | output | 1 | Bus drive enable, high during read cycles |
| wait_o | output | 1 | Cycle stretch request, active high |
| err_n | output | 1 | Corrected single-bit fault, active low |
| merr | output | 1 | Uncorrectable multi-bit fault, active high |

## Verification
The assertions assume that the processor raises `ale` only while the block is idle and that it holds the latched address, direction, byte enables and data stable for the whole cycle. The bench drives each access on a falling edge and waits until the sequence it expects has finished before it starts the next. Faults enter by forcing the array read word to a bench-encoded codeword with one or two bits flipped, and only during the cycles of the access under test. A random mix of reads, full writes and partial writes on a small address set runs against a bench copy of the memory contents.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;
  localparam int DW    = 32;
  localparam int PW    = 6;
  localparam int CW    = 40;
  localparam int NPOS  = 38;
  localparam int NBYTE = DW / 8;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_RDX, S_MRG} st_t;

  // code position of data bit idx (non power-of-two positions 1..NPOS)
  function automatic int data_pos(input int idx);
    int cnt;
    cnt = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  function automatic logic [PW-1:0] ham_par(input logic [DW-1:0] d);
    logic [PW-1:0] s;
    s = '0;
    for (int i = 0; i < DW; i++) begin
      int p;
      p = data_pos(i);
      for (int k = 0; k < PW; k++)
        if (p[k]) s[k] = s[k] ^ d[i];
    end
    return s;
  endfunction

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [PW-1:0] s;
    logic ov;
    s  = ham_par(d);
    ov = (^d) ^ (^s);
    return {1'b0, ov, s, d};
  endfunction
endpackage

// File: rtl/ecc_store.sv
module ecc_store #(
  parameter int AW = 8,
  parameter int CW = 40
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ecc_gen.sv
module ecc_gen
  import ecc_mem_pkg::*;
(
  input  logic [DW-1:0] d,
  output logic [CW-1:0] w
);
  assign w = encode(d);
endmodule

// File: rtl/ecc_check.sv
module ecc_check
  import ecc_mem_pkg::*;
(
  input  logic [CW-2:0] w,
  output logic [DW-1:0] data,
  output logic          single,
  output logic          multi
);
  logic [PW-1:0] syn;
  logic          par_bad;

  assign syn     = ham_par(w[DW-1:0]) ^ w[DW+PW-1:DW];
  assign par_bad = ^w;

  always_comb begin
    data   = w[DW-1:0];
    single = 1'b0;
    multi  = 1'b0;
    if (par_bad) begin
      if (syn == '0) begin
        single = 1'b1;
      end else if (int'(syn) <= NPOS) begin
        single = 1'b1;
        for (int i = 0; i < DW; i++)
          if (data_pos(i) == int'(syn)) data[i] = ~w[i];
      end else begin
        multi = 1'b1;
      end
    end else if (syn != '0) begin
      multi = 1'b1;
    end
  end
endmodule

// File: rtl/ecc_mem_ctrl.sv
module ecc_mem_ctrl
  import ecc_mem_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic          bsel,
  input  logic          rw,
  input  logic [3:0]    be_n,
  input  logic [AW-1:0] word_addr,
  input  logic [31:0]   data_in,
  output logic [31:0]   data_out,
  output logic          data_oe,
  output logic          wait_o,
  output logic          err_n,
  output logic          merr
);
  st_t             st;
  logic [AW-1:0]   addr_q;
  logic [3:0]      be_q;
  logic [DW-1:0]   wd_q;

  // named internal events
  logic            start;
  logic            full_wr;
  logic            arr_we;
  logic [AW-1:0]   arr_waddr;
  logic [CW-1:0]   arr_wdata;
  logic [CW-1:0]   arr_rdata;
  logic [DW-1:0]   corr_data;
  logic            fix_single;
  logic            fix_multi;
  logic            flt;
  logic [DW-1:0]   merged;
  logic [DW-1:0]   enc_src;
  logic            unused_spare;

  assign start   = ale && bsel && (st == S_IDLE);
  assign full_wr = start && !rw && (be_n == 4'b0000);
  assign unused_spare = arr_rdata[CW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      be_q   <= '1;
      wd_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          addr_q <= word_addr;
          be_q   <= be_n;
          wd_q   <= data_in;
          if (rw)                  st <= S_RD;
          else if (be_n != 4'b0000) st <= S_MRG;
        end
        S_RD:    st <= flt ? S_RDX : S_IDLE;
        S_RDX:   st <= S_IDLE;
        S_MRG:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // lane merge: enabled lanes from the bus, others from the corrected word
  for (genvar g = 0; g < NBYTE; g++) begin : g_lane
    assign merged[g*8 +: 8] = be_q[g] ? corr_data[g*8 +: 8] : wd_q[g*8 +: 8];
  end

  assign enc_src   = (st == S_MRG) ? merged : data_in;
  assign arr_we    = full_wr || (st == S_MRG);
  assign arr_waddr = (st == S_MRG) ? addr_q : word_addr;

  ecc_gen u_gen (
    .d (enc_src),
    .w (arr_wdata)
  );

  ecc_store #(.AW(AW), .CW(CW)) u_arr (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .raddr (addr_q),
    .rdata (arr_rdata)
  );

  ecc_check u_chk (
    .w      (arr_rdata[CW-2:0]),
    .data   (corr_data),
    .single (fix_single),
    .multi  (fix_multi)
  );

  assign flt      = fix_single || fix_multi;
  assign data_oe  = (st == S_RD) || (st == S_RDX);
  assign data_out = data_oe ? corr_data : '0;
  assign wait_o   = (st == S_MRG) || ((st == S_RD) && flt);
  assign err_n    = !((st != S_IDLE) && fix_single);
  assign merr     = (st != S_IDLE) && fix_multi;

  // R1: idle never stretches
  a_r1_idle_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !wait_o);
  // R3: full-word write completes without stretch or bus drive
  a_r3_full_write_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && bsel && !rw && be_n == 4'b0000 && st == S_IDLE) |=> (!wait_o && !data_oe));
  // R4: partial write stretches the next cycle
  a_r4_partial_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && bsel && !rw && be_n != 4'b0000 && st == S_IDLE) |=> wait_o);
  // R9: bus drive only follows a read start
  a_r9_oe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(ale && bsel && rw));
  // R6: multi-bit flag never pairs with the corrected flag
  a_r6_merr_not_err: assert property (@(posedge clk) disable iff (!rst_n)
    merr |-> err_n);
  // R5: a corrected read fault stretches the first read cycle
  a_r5_err_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && !err_n) |-> wait_o);
endmodule

// File: tb/sim_ecc_mem_ctrl.sv
module sim_ecc_mem_ctrl;
  localparam int AW = 8;
  localparam int NA = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ale = 1'b0, bsel = 1'b0, rw = 1'b1;
  logic [3:0]    be_n = 4'hF;
  logic [AW-1:0] word_addr = '0;
  logic [31:0]   data_in = '0;
  logic [31:0]   data_out;
  logic          data_oe, wait_o, err_n, merr;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [NA];

  always #4 clk = ~clk;

  ecc_mem_ctrl #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ale(ale), .bsel(bsel), .rw(rw), .be_n(be_n),
    .word_addr(word_addr), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .wait_o(wait_o), .err_n(err_n), .merr(merr)
  );

  // bench encoder (R10): positions listed, parity per position bit
  function automatic logic [39:0] b_enc(input logic [31:0] d);
    logic [5:0] c;
    logic [38:1] cw;
    int n;
    cw = '0;
    n = 0;
    for (int p = 1; p <= 38; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32) begin
        cw[p] = d[n];
        n++;
      end
    end
    c = '0;
    for (int p = 1; p <= 38; p++)
      if (cw[p]) c = c ^ p[5:0];
    return {1'b0, (^d) ^ (^c), c, d};
  endfunction

  function automatic logic [31:0] b_merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[i*8 +: 8] = be[i] ? old[i*8 +: 8] : nw[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] be,
                          input logic [39:0] flip);
    logic [31:0] base;
    @(negedge clk);
    ale = 1; bsel = 1; rw = 0; be_n = be; word_addr = AW'(a); data_in = d;
    if (be == 4'h0) begin
      @(negedge clk);
      ale = 0;
      chk("R3", "full write wait", {31'b0, wait_o}, 32'd0);
      chk("R9", "full write oe", {31'b0, data_oe}, 32'd0);
      model[a] = d;
    end else begin
      if (flip != 0) force u0.arr_rdata = b_enc(model[a]) ^ flip;
      @(negedge clk);
      ale = 0;
      chk("R4", "partial wait", {31'b0, wait_o}, 32'd1);
      chk("R9", "partial oe", {31'b0, data_oe}, 32'd0);
      if ($countones(flip) == 1) begin
        chk("R7", "partial err_n", {31'b0, err_n}, 32'd0);
        base = model[a];
      end else if ($countones(flip) == 2) begin
        chk("R8", "partial merr", {31'b0, merr}, 32'd1);
        base = model[a] ^ flip[31:0];
      end else begin
        base = model[a];
      end
      @(negedge clk);
      release u0.arr_rdata;
      chk("R4", "wait after writeback", {31'b0, wait_o}, 32'd0);
      model[a] = b_merge(base, d, be);
    end
  endtask

  task automatic do_read(input int a, input logic [39:0] flip, input string req);
    int nf;
    nf = $countones(flip);
    @(negedge clk);
    ale = 1; bsel = 1; rw = 1; be_n = 4'hF; word_addr = AW'(a);
    if (nf != 0) force u0.arr_rdata = b_enc(model[a]) ^ flip;
    @(negedge clk);
    ale = 0;
    chk(req, "read oe", {31'b0, data_oe}, 32'd1);
    chk(req, "read wait", {31'b0, wait_o}, (nf != 0) ? 32'd1 : 32'd0);
    chk(req, "read err_n", {31'b0, err_n}, (nf == 1) ? 32'd0 : 32'd1);
    chk(req, "read merr", {31'b0, merr}, (nf == 2) ? 32'd1 : 32'd0);
    if (nf < 2) chk(req, "read data", data_out, model[a]);
    if (nf != 0) begin
      @(negedge clk);
      chk(req, "second cycle oe", {31'b0, data_oe}, 32'd1);
      chk(req, "second cycle wait", {31'b0, wait_o}, 32'd0);
      if (nf == 1) chk(req, "second cycle data", data_out, model[a]);
    end
    @(negedge clk);
    release u0.arr_rdata;
    chk("R9", "oe after read", {31'b0, data_oe}, 32'd0);
    chk("R9", "data idle", data_out, 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    chk("R9", "reset oe", {31'b0, data_oe}, 32'd0);
    chk("R1", "reset wait", {31'b0, wait_o}, 32'd0);
    chk("R5", "reset err_n", {31'b0, err_n}, 32'd1);
    chk("R6", "reset merr", {31'b0, merr}, 32'd0);
    rst_n = 1;
    for (int a = 0; a < NA; a++) do_write(a, 32'hA5000000 + a * 32'h01010101, 4'h0, '0);
    do_read(3, '0, "R2");
    do_read(5, 40'h1, "R5");
    do_read(5, 40'h1 << 37, "R5");
    do_read(6, 40'h1 << 38, "R10");
    do_read(7, (40'h1 << 2) | (40'h1 << 20), "R6");
    // R1: strobe without board select
    @(negedge clk);
    ale = 1; bsel = 0; rw = 0; be_n = 4'h0; word_addr = AW'(2); data_in = 32'hDEADBEEF;
    @(negedge clk);
    chk("R1", "no select oe", {31'b0, data_oe}, 32'd0);
    ale = 0; bsel = 1;
    @(negedge clk);
    bsel = 0;
    do_read(2, '0, "R1");
    do_write(8, 32'h11223344, 4'b1010, '0);
    do_read(8, '0, "R4");
    do_write(9, 32'hCAFEF00D, 4'b0111, 40'h1 << 12);
    do_read(9, '0, "R7");
    do_write(10, 32'h0BADC0DE, 4'b1100, (40'h1 << 33) | (40'h1 << 34));
    do_read(10, '0, "R8");
    for (int n = 0; n < 120; n++) begin
      int a, op, b1, b2;
      a  = int'($urandom % NA);
      op = int'($urandom % 5);
      b1 = int'($urandom % 39);
      b2 = (b1 + 1 + int'($urandom % 38)) % 39;
      case (op)
        0: do_write(a, $urandom, 4'h0, '0);
        1: do_write(a, $urandom, 4'($urandom % 15 + 1), '0);
        2: do_read(a, '0, "R2");
        3: do_read(a, 40'h1 << b1, "R5");
        default: do_write(a, $urandom, 4'($urandom % 15 + 1), 40'h1 << b1);
      endcase
      if (n % 10 == 0) do_read(a, (40'h1 << b1) | (40'h1 << b2), "R6");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule